// File: doc/BRIEF.md
# Error-Correcting Register File

This block is a small register file whose every entry is kept as a 39-bit codeword: 32 data bits, six Hamming check bits and one overall parity bit. On a read the stored codeword is decoded. A single flipped bit is repaired before the data leaves the block. A pair of flipped bits is recognised and flagged as unusable. Each read returns a 2-bit integrity status alongside the data, so the consumer can tell clean data, repaired data and lost data apart.

A fault-injection input XORs a chosen mask into the stored codeword at the selected index. Upsets can therefore be placed on exact bit positions, which allows a test to exercise every correction and detection path. Reads, writes and injections all share one index input. Read results are registered.

Top module: `secded_regfile`

## Requirements
- R1: Synchronous active-high reset sets rd_data to 0 and rd_status to 00, and clears every entry, so a later read of any index returns 0 with status 00.
- R2: A cycle with wr_en high stores wr_data at index idx. A later read of that index with rd_en high returns the same word with status 00 on the clock edge that samples rd_en, so the result is seen one cycle after the strobe.
- R3: While rd_en is low, rd_data and rd_status keep their values, even across writes and injections.
- R4: If exactly one bit of a stored codeword is flipped, at any of the 39 bit positions, a read returns the original data with status 01.
- R5: If exactly two bits of a stored codeword are flipped, a read returns status 10. The data is then the stored data bits taken without correction. The codeword layout is as follows. Codeword bit b holds position b+1. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bit 0 upward fill positions 3, 5, 6, 7, 9 and onward in ascending order, up to position 38. Overall parity sits at position 39 (bit 38).
- R6: rd_status never takes the value 11.
- R7: If wr_en and rd_en are high in the same cycle, the write is performed and the read returns the contents the index held before that write.
- R8: A cycle with inj_en high and wr_en low XORs inj_mask into the stored codeword at idx. Injecting the same mask twice restores the entry. When wr_en is also high, the write wins and the mask is dropped.
- R9: A write or an injection changes only the entry at idx. Every other entry reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx | input | 3 | Entry index for read, write and injection |
| wr_data | input | 32 | Word to store |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| inj_en | input | 1 | Fault-injection strobe (test use) |
| inj_mask | input | 39 | Bits to flip in the stored codeword |
| rd_data | output | 32 | Registered read data |
| rd_status | output | 2 | Registered status: 00 clean, 01 corrected, 10 uncorrectable |

## Verification
A wrong check-bit equation or a misplaced data bit shows up at the first read of that entry. A fault in the encoder produces a non-zero status on data that was never disturbed. A fault in the decoder or in the bit placement produces wrong data after a single- or double-bit injection. Each single-bit position and every pair of positions is injected in turn, so a fault on any one codeword bit becomes visible one cycle after the read that follows the injection. A stale or leaking storage entry appears as a wrong word when another index is read back.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FAIL  = 2'b10
  } status_e;

  // Smallest number of Hamming check bits that covers dw data bits.
  function automatic int chk_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 32,
  localparam int P_W   = secded_pkg::chk_bits(DATA_W),
  localparam int HAM_N = DATA_W + P_W,
  localparam int CW_W  = HAM_N + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);

  function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    logic            b;
    int              di;
    c  = '0;
    di = 0;
    // scatter data over non-power-of-two positions, ascending
    for (int p = 1; p <= HAM_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[di];
        di++;
      end
    end
    // each check bit covers positions whose index has its bit set
    for (int k = 0; k < P_W; k++) begin
      b = 1'b0;
      for (int p = 1; p <= HAM_N; p++)
        if (((p >> k) & 1) != 0) b = b ^ c[p-1];
      c[(1 << k) - 1] = b;
    end
    c[CW_W-1] = ^c[CW_W-2:0];
    return c;
  endfunction

  assign cw = encode(data);

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int P_W   = secded_pkg::chk_bits(DATA_W),
  localparam int HAM_N = DATA_W + P_W,
  localparam int CW_W  = HAM_N + 1
) (
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data,
  output status_e           status
);

  always_comb begin
    logic [CW_W-1:0] c;
    int              syn;
    int              di;
    logic            odd;
    c   = cw;
    syn = 0;
    for (int p = 1; p <= HAM_N; p++)
      if (c[p-1]) syn = syn ^ p;
    odd = ^c;
    if (!odd && syn == 0) begin
      status = ST_CLEAN;
    end else if (odd && syn <= HAM_N) begin
      // syn==0 with odd parity: only the overall bit flipped
      if (syn != 0) c[syn-1] = ~c[syn-1];
      status = ST_FIXED;
    end else begin
      status = ST_FAIL;
    end
    data = '0;
    di   = 0;
    for (int p = 1; p <= HAM_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        data[di] = c[p-1];
        di++;
      end
    end
  end

endmodule

// File: rtl/secded_store.sv
module secded_store #(
  parameter int DEPTH   = 8,
  parameter int CW_W    = 39,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [CW_W-1:0]  wr_cw,
  input  logic             inj_en,
  input  logic [CW_W-1:0]  inj_mask,
  output logic [CW_W-1:0]  rd_cw
);

  logic [CW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_cw;
    end else if (inj_en) begin
      mem[idx] <= mem[idx] ^ inj_mask;
    end
  end

  // read sees the contents before this edge's update
  assign rd_cw = mem[idx];

  p_write_store_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(idx)] == $past(wr_cw));

  p_inject_xor_r8: assert property (@(posedge clk) disable iff (rst)
    (inj_en && !wr_en) |=> mem[$past(idx)] == ($past(mem[idx]) ^ $past(inj_mask)));

endmodule

// File: rtl/secded_regfile.sv
module secded_regfile
  import secded_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CW_W   = DATA_W + secded_pkg::chk_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              inj_en,
  input  logic [CW_W-1:0]   inj_mask,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_status
);

  logic [CW_W-1:0]   enc_cw;
  logic [CW_W-1:0]   rd_cw;
  logic [DATA_W-1:0] dec_data;
  status_e           dec_status;
  status_e           st_q;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data (wr_data),
    .cw   (enc_cw)
  );

  secded_store #(.DEPTH(DEPTH), .CW_W(CW_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .idx      (idx),
    .wr_en    (wr_en),
    .wr_cw    (enc_cw),
    .inj_en   (inj_en),
    .inj_mask (inj_mask),
    .rd_cw    (rd_cw)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .cw     (rd_cw),
    .data   (dec_data),
    .status (dec_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      st_q    <= ST_CLEAN;
    end else if (rd_en) begin
      rd_data <= dec_data;
      st_q    <= dec_status;
    end
  end

  assign rd_status = st_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && rd_status == 2'b00));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_data) && $stable(rd_status)));

  p_status_legal_r6: assert property (@(posedge clk) disable iff (rst)
    rd_status != 2'b11);

  p_clean_after_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) ##1 (rd_en && !wr_en && !inj_en && $stable(idx))
      |=> (rd_status == 2'b00 && rd_data == $past(wr_data, 2)));

endmodule

// File: tb/tb_secded_regfile.sv
module tb_secded_regfile;

  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int CW = 39;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          inj_en = 1'b0;
  logic [CW-1:0] inj_mask = '0;
  logic [DW-1:0] rd_data;
  logic [1:0]    rd_status;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  secded_regfile dut (
    .clk(clk), .rst(rst), .idx(idx), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .inj_en(inj_en), .inj_mask(inj_mask),
    .rd_data(rd_data), .rd_status(rd_status)
  );

  // data bit carried by codeword bit b, or -1 for check/parity bits
  function automatic int data_of_bit(input int b);
    int pos, n;
    pos = b + 1;
    if (pos >= 39 || (pos & (pos - 1)) == 0) return -1;
    n = 0;
    for (int q = 1; q < pos; q++)
      if ((q & (q - 1)) != 0) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; inj_en = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input int i, input logic [DW-1:0] d);
    idx = i[2:0]; wr_data = d; wr_en = 1; rd_en = 0; inj_en = 0;
    @(negedge clk);
    wr_en = 0;
    model[i] = d;
  endtask

  task automatic do_inject(input int i, input logic [CW-1:0] m);
    idx = i[2:0]; inj_mask = m; inj_en = 1; wr_en = 0; rd_en = 0;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic do_read(input int i);
    idx = i[2:0]; rd_en = 1; wr_en = 0; inj_en = 0;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic read_check(input int i, input logic [DW-1:0] exp_d,
                            input logic [1:0] exp_s, input string tag);
    do_read(i);
    chk(rd_data == exp_d, tag, 64'(rd_data), 64'(exp_d));
    chk(rd_status == exp_s, tag, 64'(rd_status), 64'(exp_s));
    chk(rd_status != 2'b11, "R6", 64'(rd_status), 64'(2'b00));
  endtask

  initial begin
    logic [DW-1:0] d, e, hd;
    logic [1:0] hs;
    int r, di;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_data == 0 && rd_status == 2'b00, "R1", 64'({rd_status, rd_data}), 64'(0));
    rst = 0;
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = '0;
      read_check(i, 32'h0, 2'b00, "R1");
    end

    // R2: write / read back patterns
    for (int i = 0; i < DEPTH; i++) do_write(i, 32'h1357_9BDF * (i + 1) ^ (32'h1 << (i * 4)));
    for (int i = 0; i < DEPTH; i++) read_check(i, model[i], 2'b00, "R2");
    do_write(2, 32'hFFFF_FFFF); read_check(2, 32'hFFFF_FFFF, 2'b00, "R2");
    do_write(5, 32'h0000_0000); read_check(5, 32'h0000_0000, 2'b00, "R2");
    do_write(6, 32'h8000_0001); read_check(6, 32'h8000_0001, 2'b00, "R2");

    // R3: outputs hold across idle, write and injection
    hd = rd_data; hs = rd_status;
    idle();
    do_write(1, 32'hDEAD_BEEF);
    do_inject(0, 39'h1);
    chk(rd_data == hd && rd_status == hs, "R3", 64'({rd_status, rd_data}), 64'({hs, hd}));
    do_inject(0, 39'h1);
    read_check(0, model[0], 2'b00, "R8");

    // R4: every single-bit position corrected
    for (int b = 0; b < CW; b++) begin
      r = b % DEPTH;
      d = 32'hA5C3_0F1E ^ (32'h0101_0101 * b);
      do_write(r, d);
      do_inject(r, 39'(1) << b);
      read_check(r, d, 2'b01, "R4");
    end

    // R5: every pair of positions detected, data uncorrected
    for (int a = 0; a < CW; a++) begin
      for (int b = a + 1; b < CW; b++) begin
        r = (a + b) % DEPTH;
        d = 32'h6B29_D4C7 ^ (32'h0001_0001 * a) ^ (32'h0100_0100 * b);
        do_write(r, d);
        do_inject(r, (39'(1) << a) | (39'(1) << b));
        e = d;
        di = data_of_bit(a); if (di >= 0) e[di] = ~e[di];
        di = data_of_bit(b); if (di >= 0) e[di] = ~e[di];
        read_check(r, e, 2'b10, "R5");
        do_write(r, d);
      end
    end

    // R7: simultaneous write and read returns previous contents
    do_write(4, 32'h1111_2222);
    idx = 3'd4; wr_data = 32'h3333_4444; wr_en = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk(rd_data == 32'h1111_2222 && rd_status == 2'b00, "R7", 64'({rd_status, rd_data}), 64'({2'b00, 32'h1111_2222}));
    model[4] = 32'h3333_4444;
    read_check(4, 32'h3333_4444, 2'b00, "R7");

    // R8: write wins over injection in the same cycle
    idx = 3'd3; wr_data = 32'hCAFE_F00D; wr_en = 1; inj_en = 1; inj_mask = 39'h3;
    @(negedge clk);
    wr_en = 0; inj_en = 0;
    model[3] = 32'hCAFE_F00D;
    read_check(3, 32'hCAFE_F00D, 2'b00, "R8");
    // R8: double injection of the same two bits restores the entry
    do_inject(3, 39'h50); do_inject(3, 39'h50);
    read_check(3, 32'hCAFE_F00D, 2'b00, "R8");

    // R9: isolation between entries
    for (int i = 0; i < DEPTH; i++) do_write(i, 32'h0F0F_0000 + i);
    do_write(3, 32'hFFFF_0000);
    do_inject(5, 39'h7);
    for (int i = 0; i < DEPTH; i++)
      if (i != 5) read_check(i, model[i], 2'b00, "R9");

    // R1: reset mid-run clears all entries
    rst = 1; @(negedge clk); rst = 0;
    chk(rd_data == 0 && rd_status == 2'b00, "R1", 64'({rd_status, rd_data}), 64'(0));
    for (int i = 0; i < DEPTH; i++) read_check(i, 32'h0, 2'b00, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule